// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block derives the SCL waveform for an I2C master from the peripheral clock. Software packs two divider fields, one for the low half and one for the high half of the SCL period, into a single 32-bit word and writes it with a one-cycle strobe. While enabled, the generator alternates between a low phase of 8 × (low field + 1) clocks and a high phase of 8 × (high field + 1) clocks. The full period is therefore 8 × ((low + 1) + (high + 1)) clocks, and the two halves can differ in length. With both fields zero the period is 16 clocks, the fastest rate. A driver that splits an even total gives equal halves. For an odd total it gives the extra unit to the high half.

The bit engine of the master uses the outputs as follows. The level flags `in_low` and `in_high` mark which half is running. One-cycle ticks mark each falling edge and each rising edge of SCL. A combined `edge_tick` marks any edge. A new divider word is held in a programmed register. The generator copies it into the running copy only when a period starts, so changing the rate never produces a shortened or lengthened half.

The control is a three-state machine:
- `ST_IDLE`: disabled. SCL is high and the counter is zero.
- `ST_LOW`: SCL is low.
- `ST_HIGH`: SCL is high.

The transitions are:
- start, `ST_IDLE`→`ST_LOW`, when enable is seen. The programmed divider is loaded.
- low_done, `ST_LOW`→`ST_HIGH`, when the low count expires.
- wrap, `ST_HIGH`→`ST_LOW`, when the high count expires and enable is still high. The programmed divider is loaded.
- abort, any state→`ST_IDLE`, when enable is low.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, `scl_out` is 1, all three ticks are 0, and `in_low` and `in_high` are 0.
- R2: The low phase lasts 8 × (L + 1) clocks, counted from the fall tick to the next rise tick. L is bits [15:0] of the divider word.
- R3: The high phase lasts 8 × (H + 1) clocks, counted from the rise tick to the next fall tick. H is bits [31:16] of the divider word.
- R4: With both fields zero, each phase lasts 8 clocks, so the period is 16 clocks.
- R5: From `ST_IDLE`, the first rising clock edge that samples `enable` high drives `scl_out` low and raises `fall_tick`. The phase that starts there uses the divider programmed at that point.
- R6: A divider write made while running does not change the current low or high phase. It takes effect from the next low phase.
- R7: One clock after `enable` is sampled low, `scl_out` is 1. If SCL was low, that edge carries a `rise_tick`. SCL then stays high with no ticks and both phase flags at 0 until re-enabled. A re-enabled low phase runs for its full length, because the counter restarts from zero.
- R8: `fall_tick` is 1 for exactly the cycle in which `scl_out` first shows 0. `rise_tick` is 1 for exactly the cycle in which `scl_out` first shows 1. `edge_tick` is their OR, and the two never coincide.
- R9: While enabled, `in_low` equals NOT `scl_out` and `in_high` equals `scl_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator when high |
| div_wr | input | 1 | One-cycle write strobe for the divider word |
| div_wdata | input | 32 | Divider word, low field [15:0], high field [31:16] |
| scl_out | output | 1 | Generated SCL level |
| in_low | output | 1 | High during the low phase |
| in_high | output | 1 | High during the high phase |
| fall_tick | output | 1 | One-cycle pulse at each SCL falling edge |
| rise_tick | output | 1 | One-cycle pulse at each SCL rising edge |
| edge_tick | output | 1 | One-cycle pulse at either SCL edge |

## Verification
The main function is tried with several divider pairs:
- Both fields zero, which shows the 16-clock floor.
- Pairs with only one field non-zero, which show that the two fields land in their own halves and are not swapped.
- Unequal non-zero pairs, such as an odd split that lengthens the high half, which confirm the multiply-by-eight and the +1 offset for each half.

A rewrite issued in the middle of a low phase separates a design that reloads at the period boundary from one that reloads at once. Disabling in the middle of a phase and then re-enabling separates a counter that is cleared on abort from one that is only paused.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;
endpackage

// File: rtl/scl_div_shadow.sv
module scl_div_shadow #(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2*DIV_W-1:0] wr_word,
    input  logic               load,
    output logic [DIV_W-1:0]   act_lo,
    output logic [DIV_W-1:0]   act_hi
);
    logic [DIV_W-1:0] prog_lo, prog_hi;

    // programmed copy: follows software writes at once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_lo <= '0;
            prog_hi <= '0;
        end else if (wr_en) begin
            prog_lo <= wr_word[DIV_W-1:0];
            prog_hi <= wr_word[2*DIV_W-1:DIV_W];
        end
    end

    // running copy: changes only at a period start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_lo <= '0;
            act_hi <= '0;
        end else if (load) begin
            act_lo <= prog_lo;
            act_hi <= prog_hi;
        end
    end

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_lo) && $stable(act_hi)));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_clkgen_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    output logic             load,
    output logic             scl_o,
    output logic             fall_o,
    output logic             rise_o,
    output logic             in_low_o,
    output logic             in_high_o
);
    scl_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = '0;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin
                    state_n = ST_LOW;
                    load    = 1'b1;
                end
            end
            ST_LOW: begin
                if (!enable) begin
                    state_n = ST_IDLE;
                end else if (cnt_q == lim_lo) begin
                    state_n = ST_HIGH;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (!enable) begin
                    state_n = ST_IDLE;
                end else if (cnt_q == lim_hi) begin
                    state_n = ST_LOW;
                    load    = 1'b1;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // registered outputs, taken from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_o     <= 1'b1;
            fall_o    <= 1'b0;
            rise_o    <= 1'b0;
            in_low_o  <= 1'b0;
            in_high_o <= 1'b0;
        end else begin
            scl_o     <= (state_n != ST_LOW);
            fall_o    <= (state_n == ST_LOW) && scl_o;
            rise_o    <= (state_n != ST_LOW) && !scl_o;
            in_low_o  <= (state_n == ST_LOW);
            in_high_o <= (state_n == ST_HIGH);
        end
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && cnt_q == '0 && !in_low_o && !in_high_o));

    // R2
    cnt_lo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> (cnt_q <= lim_lo));

    // R3
    cnt_hi_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> (cnt_q <= lim_hi));

    // R8
    scl_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o != $past(scl_o)) |-> (rise_o || fall_o));

    // R8
    tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int DIV_W    = 16,
    parameter int PRE_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               div_wr,
    input  logic [2*DIV_W-1:0] div_wdata,
    output logic               scl_out,
    output logic               in_low,
    output logic               in_high,
    output logic               fall_tick,
    output logic               rise_tick,
    output logic               edge_tick
);
    localparam int CNT_W = DIV_W + PRE_LOG2;

    logic [DIV_W-1:0] act_lo, act_hi;
    logic [CNT_W-1:0] lim_lo, lim_hi;
    logic             load;

    // last count of a phase: 2^PRE_LOG2 * (field+1) - 1
    assign lim_lo = {act_lo, {PRE_LOG2{1'b1}}};
    assign lim_hi = {act_hi, {PRE_LOG2{1'b1}}};

    scl_div_shadow #(.DIV_W(DIV_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (div_wr),
        .wr_word (div_wdata),
        .load    (load),
        .act_lo  (act_lo),
        .act_hi  (act_hi)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .lim_lo    (lim_lo),
        .lim_hi    (lim_hi),
        .load      (load),
        .scl_o     (scl_out),
        .fall_o    (fall_tick),
        .rise_o    (rise_tick),
        .in_low_o  (in_low),
        .in_high_o (in_high)
    );

    assign edge_tick = fall_tick | rise_tick;

    // R9
    phase_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_low || in_high) |-> (in_low == !scl_out));
endmodule

// File: tb/scl_clkgen_bench.sv
`timescale 1ns/1ps
module scl_clkgen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        div_wr = 1'b0;
    logic [31:0] div_wdata = '0;
    logic        scl_out, in_low, in_high, fall_tick, rise_tick, edge_tick;

    int checks = 0;
    int errors = 0;
    int flag_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scl_clkgen u_scl_clkgen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_wr(div_wr),
        .div_wdata(div_wdata), .scl_out(scl_out), .in_low(in_low),
        .in_high(in_high), .fall_tick(fall_tick), .rise_tick(rise_tick),
        .edge_tick(edge_tick)
    );

    // {L, H, expected low length, expected high length}
    localparam logic [63:0] VEC [5] = '{
        {16'd0, 16'd0, 16'd8,  16'd8},
        {16'd1, 16'd0, 16'd16, 16'd8},
        {16'd0, 16'd3, 16'd8,  16'd32},
        {16'd5, 16'd2, 16'd48, 16'd24},
        {16'd2, 16'd3, 16'd24, 16'd32}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_div(input logic [15:0] l, input logic [15:0] h);
        @(negedge clk);
        div_wr = 1'b1;
        div_wdata = {h, l};
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    // counts clocks up to and including the next SCL edge tick
    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (in_low != !scl_out || in_high != scl_out) flag_bad++;
            if ((fall_tick && rise_tick) || (edge_tick != (fall_tick | rise_tick))) flag_bad++;
        end while (!edge_tick && n < 5000);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lo, hi, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(scl_out && !fall_tick && !rise_tick && !edge_tick && !in_low && !in_high,
            "R1 reset outputs", {scl_out, fall_tick, rise_tick, in_low, in_high}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        foreach (VEC[i]) begin
            wr_div(VEC[i][63:48], VEC[i][47:32]);
            @(negedge clk);
            enable = 1'b1;
            @(negedge clk);
            // R5 first falling edge on the first enabled clock edge
            chk(fall_tick && !scl_out, "R5 start edge", {fall_tick, scl_out}, 2'b10);
            gap(lo);
            // R2 low phase length, R4 for the zero vector
            chk(lo == int'(VEC[i][31:16]) && rise_tick, "R2/R4 low length", lo, int'(VEC[i][31:16]));
            gap(hi);
            // R3 high phase length
            chk(hi == int'(VEC[i][15:0]) && fall_tick, "R3 high length", hi, int'(VEC[i][15:0]));
            enable = 1'b0;
            repeat (3) @(negedge clk);
        end
        // R4 period of 16 clocks with both fields zero
        wr_div(16'd0, 16'd0);
        enable = 1'b1;
        @(negedge clk);
        gap(lo);
        gap(hi);
        chk(lo + hi == 16, "R4 min period", lo + hi, 16);

        // R6 rewrite during the low phase waits for the next period
        enable = 1'b0;
        wr_div(16'd3, 16'd3);
        enable = 1'b1;
        @(negedge clk);
        repeat (5) @(negedge clk);
        div_wr = 1'b1;
        div_wdata = {16'd1, 16'd0};
        @(negedge clk);
        div_wr = 1'b0;
        gap(n);
        chk(n + 6 == 32, "R6 current low kept", n + 6, 32);
        gap(n);
        chk(n == 32, "R6 current high kept", n, 32);
        gap(n);
        chk(n == 8, "R6 new low applied", n, 8);
        gap(n);
        chk(n == 16, "R6 new high applied", n, 16);

        // R9 and R8 across every cycle seen so far
        chk(flag_bad == 0, "R9/R8 flags and ticks", flag_bad, 0);

        // R7 abort during low phase
        wr_div(16'd4, 16'd4);
        repeat (10) @(negedge clk);
        if (!in_low) gap(n);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_out && rise_tick, "R7 abort raises scl", {scl_out, rise_tick}, 2'b11);
        n = 0;
        repeat (20) begin
            @(negedge clk);
            if (!scl_out || edge_tick || in_low || in_high) n++;
        end
        chk(n == 0, "R7 idle stays high", n, 0);
        enable = 1'b1;
        @(negedge clk);
        chk(fall_tick, "R5 restart edge", fall_tick, 1);
        gap(n);
        chk(n == 40, "R7 counter restarted", n, 40);
        // R7 abort during high phase: no edge
        repeat (4) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_out && !edge_tick, "R7 abort in high", {scl_out, edge_tick}, 2'b10);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule